// File: doc/BRIEF.md
# Signed-Correction Shift-Add Periphery for a Compute-in-Memory Column

This block sits after the bit-line read-out of one column in a digital compute-in-memory macro. Each cycle it receives the 1-bit partial products of all rows of that column, counts them, and folds the count into a most-significant-first shift-accumulator. When signed operation is enabled, it adds the extra terms that two's-complement operands need under three bit-level mappings, so that one adder tree serves all three mappings. The mappings are bit-serial input with parallel weights, input-side parallel, and input- plus output-side parallel.

Three independent multiplexers select the correction terms. The lift path adds twice the first step's column count in the two input-side modes. The tap path adds twice a secondary subset sum on the last step in the same two modes. The serial path gives the first step of the bit-serial mode a negative weight. The subset sum covers a fixed set of row indices, and that set grows when the data width is 4 bits. The main count reuses the subset sum, so the main tree only adds the rows outside the subset. With signed operation off, all three multiplexers select zero and the block is a plain unsigned shift-accumulator.

Top module: `signcorr_periph`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, result_o is 0 and valid_o is 0.
- R2: With signed_i low, in every mode, a group of steps yields the sum of step popcounts weighted MSB-first, result = sum over k of c_k * 2^(n-1-k), where c_k is the number of ones in rows_i at step k and n is the number of steps.
- R3: result_o updates one cycle after each accepted step (step_valid_i high). valid_o is high exactly in the cycle after a step with last_i high, and low after a step without last_i.
- R4: A step with first_i high discards the previous accumulator value instead of doubling it.
- R5: In mode_i = 0 (bit-serial), with signed_i high, the first step adds -c instead of +c, so a single-step group yields -c modulo 2^16.
- R6: In mode_i = 1 or 2 (input-side modes), with signed_i high, the first step adds an extra 2*c.
- R7: In the input-side modes, with signed_i high, the last step adds an extra 2*s. With wide_i = 1 (8-bit), s counts the ones among rows whose index modulo 8 equals 7.
- R8: With wide_i = 0 (4-bit), s also counts the ones among rows whose index modulo 8 equals 3.
- R9: Modes 1 and 2 give identical results for identical stimulus.
- R10: A cycle with step_valid_i low leaves result_o unchanged and valid_o low, whatever rows_i holds.
- R11: The accumulator is 16 bits wide and wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_valid_i | input | 1 | Accept one accumulation step this cycle |
| first_i | input | 1 | Step is the first of a group |
| last_i | input | 1 | Step is the last of a group |
| mode_i | input | 2 | 0 bit-serial, 1 input-side, 2 input+output-side |
| wide_i | input | 1 | 1 = 8-bit data, 0 = 4-bit data |
| signed_i | input | 1 | Enable signed correction terms |
| rows_i | input | 64 | Per-row 1-bit partial products of the column |
| result_o | output | 16 | Accumulated, corrected column result |
| valid_o | output | 1 | result_o holds a completed group |

## Verification
The assertions assume that mode, width and sign select are held steady through a group, and that every group opens with first_i. The single-step properties also assume that first_i and last_i may both be high on one step. The stimulus opens every group with first_i, holds the configuration fixed until last_i, and drops step_valid_i between groups. Idle cycles change rows_i, so any leakage into the held result would show at the output.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned ROWS_DEF  = 64;
  localparam int unsigned ACC_W_DEF = 16;
  localparam int unsigned GROUP_DEF = 8;

  typedef enum logic [1:0] {
    MAP_SERIAL = 2'd0,
    MAP_INSIDE = 2'd1,
    MAP_INOUT  = 2'd2,
    MAP_RSVD   = 2'd3
  } map_e;

  // both input-side mappings share one input ordering, hence one path
  function automatic logic map_is_input_side(logic [1:0] m);
    return m != MAP_SERIAL;
  endfunction
endpackage

// File: rtl/sc_popcount.sv
module sc_popcount #(
  parameter int unsigned N = 16,
  parameter int unsigned W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] count_o
);
  localparam int unsigned LVLS = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned P    = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int unsigned CNT = P >> l;
    logic [W-1:0] s [CNT];
    for (genvar i = 0; i < CNT; i++) begin : g_n
      if (l == 0) begin : g_leaf
        if (i < N) begin : g_used
          assign s[i] = W'(bits_i[i]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end else begin : g_add
        assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
      end
    end
  end

  assign count_o = g_lvl[LVLS].s[0];
endmodule

// File: rtl/sc_subset_tap.sv
module sc_subset_tap #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned GROUP = 8
) (
  input  logic [ROWS-1:0]           rows_i,
  input  logic                      wide_i,
  output logic [2*(ROWS/GROUP)-1:0] tap_o,
  output logic [ROWS-1:0]           rest_o
);
  localparam int unsigned NG     = ROWS / GROUP;
  localparam int unsigned HI_OFS = GROUP - 1;
  localparam int unsigned LO_OFS = GROUP - 5;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar k = 0; k < GROUP; k++) begin : g_row
      localparam int unsigned R = g * GROUP + k;
      if (k == HI_OFS) begin : g_hi
        assign tap_o[2*g]  = rows_i[R];
        assign rest_o[R]   = 1'b0;
      end else if (k == LO_OFS) begin : g_lo
        // joins the subset only for narrow data
        assign tap_o[2*g+1] = rows_i[R] & ~wide_i;
        assign rest_o[R]    = rows_i[R] & wide_i;
      end else begin : g_plain
        assign rest_o[R] = rows_i[R];
      end
    end
  end
endmodule

// File: rtl/sc_corr_mux.sv
module sc_corr_mux
  import sc_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned SUB_W = 5,
  parameter int unsigned ACC_W = 16
) (
  input  logic [1:0]       mode_i,
  input  logic             signed_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] col_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic [ACC_W-1:0] lift_o,
  output logic [ACC_W-1:0] tap_o,
  output logic [ACC_W-1:0] ser_o
);
  logic side, sel_lift, sel_tap, sel_ser;
  logic [ACC_W-1:0] col_x2, sub_x2;

  assign side     = map_is_input_side(mode_i);
  assign sel_lift = signed_i & side & first_i;
  assign sel_tap  = signed_i & side & last_i;
  assign sel_ser  = signed_i & ~side & first_i;

  assign col_x2 = ACC_W'({col_i, 1'b0});
  assign sub_x2 = ACC_W'({sub_i, 1'b0});

  always_comb begin
    lift_o = sel_lift ? col_x2 : '0;
    tap_o  = sel_tap  ? sub_x2 : '0;
    ser_o  = sel_ser  ? (ACC_W'(0) - col_x2) : '0;
  end
endmodule

// File: rtl/signcorr_periph.sv
module signcorr_periph
  import sc_pkg::*;
#(
  parameter int unsigned ROWS  = ROWS_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned GROUP = GROUP_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_valid_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [1:0]       mode_i,
  input  logic             wide_i,
  input  logic             signed_i,
  input  logic [ROWS-1:0]  rows_i,
  output logic [ACC_W-1:0] result_o,
  output logic             valid_o
);
  localparam int unsigned NG    = ROWS / GROUP;
  localparam int unsigned SUB_N = 2 * NG;
  localparam int unsigned SUB_W = $clog2(SUB_N + 1);
  localparam int unsigned CNT_W = $clog2(ROWS + 1);

  logic [SUB_N-1:0] tap_bits;
  logic [ROWS-1:0]  rest_bits;
  logic [SUB_W-1:0] sub_sum;
  logic [CNT_W-1:0] rest_sum, col_sum;
  logic [ACC_W-1:0] lift, tap, ser, acc_base, acc_next, acc_q;
  logic             valid_q;

  sc_subset_tap #(.ROWS(ROWS), .GROUP(GROUP)) u_tap (
    .rows_i (rows_i),
    .wide_i (wide_i),
    .tap_o  (tap_bits),
    .rest_o (rest_bits)
  );

  // secondary tree: a quarter of the rows at most
  sc_popcount #(.N(SUB_N), .W(SUB_W)) u_sub_tree (
    .bits_i  (tap_bits),
    .count_o (sub_sum)
  );

  sc_popcount #(.N(ROWS), .W(CNT_W)) u_main_tree (
    .bits_i  (rest_bits),
    .count_o (rest_sum)
  );

  // subset is summed first and reused for the column total
  assign col_sum = rest_sum + CNT_W'(sub_sum);

  sc_corr_mux #(.CNT_W(CNT_W), .SUB_W(SUB_W), .ACC_W(ACC_W)) u_corr (
    .mode_i   (mode_i),
    .signed_i (signed_i),
    .first_i  (first_i),
    .last_i   (last_i),
    .col_i    (col_sum),
    .sub_i    (sub_sum),
    .lift_o   (lift),
    .tap_o    (tap),
    .ser_o    (ser)
  );

  assign acc_base = first_i ? '0 : {acc_q[ACC_W-2:0], 1'b0};
  assign acc_next = acc_base + ACC_W'(col_sum) + lift + tap + ser;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step_valid_i & last_i;
      if (step_valid_i) acc_q <= acc_next;
    end
  end

  assign result_o = acc_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/signcorr_periph_chk.sv
module signcorr_periph_chk #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_valid_i,
  input logic             first_i,
  input logic             last_i,
  input logic [1:0]       mode_i,
  input logic             signed_i,
  input logic [ROWS-1:0]  rows_i,
  input logic [ACC_W-1:0] result_o,
  input logic             valid_o
);
  logic [ACC_W-1:0] cnt_now;
  logic single;
  always_comb cnt_now = ACC_W'($countones(rows_i));
  assign single = step_valid_i & first_i & last_i;

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (result_o == '0 && !valid_o));

  p_last_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_i && last_i) |=> valid_o);

  p_valid_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(step_valid_i && last_i));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_valid_i |=> ($stable(result_o) && !valid_o));

  p_plain_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single && !signed_i) |=> result_o == $past(cnt_now));

  p_serial_negate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single && signed_i && mode_i == 2'd0) |=> ACC_W'(result_o + $past(cnt_now)) == '0);
endmodule

bind signcorr_periph signcorr_periph_chk #(.ROWS(ROWS), .ACC_W(ACC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_valid_i (step_valid_i),
  .first_i      (first_i),
  .last_i       (last_i),
  .mode_i       (mode_i),
  .signed_i     (signed_i),
  .rows_i       (rows_i),
  .result_o     (result_o),
  .valid_o      (valid_o)
);

// File: tb/signcorr_periph_test.sv
`timescale 1ns/1ps
module signcorr_periph_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0, first = 1'b0, last = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        wide = 1'b1, sgn = 1'b0;
  logic [63:0] rows = '0;
  logic [15:0] result;
  logic        valid;
  int          n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  signcorr_periph uut (
    .clk_i(clk), .rst_ni(rst_n), .step_valid_i(step_valid), .first_i(first),
    .last_i(last), .mode_i(mode), .wide_i(wide), .signed_i(sgn),
    .rows_i(rows), .result_o(result), .valid_o(valid)
  );

  // {mode[1:0], wide, signed, steps[2:0], pattern[63:0]}
  localparam logic [70:0] TBL [10] = '{
    {2'd0, 1'b1, 1'b0, 3'd3, 64'hF0F0_1234_8000_0001},
    {2'd1, 1'b1, 1'b0, 3'd4, 64'h0123_4567_89AB_CDEF},
    {2'd0, 1'b1, 1'b1, 3'd4, 64'hFFFF_0000_FFFF_0000},
    {2'd0, 1'b0, 1'b1, 3'd1, 64'hAAAA_5555_AAAA_5555},
    {2'd1, 1'b1, 1'b1, 3'd4, 64'h8080_8080_0F0F_0F0F},
    {2'd2, 1'b1, 1'b1, 3'd4, 64'h8080_8080_0F0F_0F0F},
    {2'd1, 1'b0, 1'b1, 3'd3, 64'h0808_0808_8888_0000},
    {2'd2, 1'b0, 1'b1, 3'd3, 64'h0808_0808_8888_0000},
    {2'd2, 1'b1, 1'b1, 3'd1, 64'hDEAD_BEEF_0BAD_F00D},
    {2'd1, 1'b0, 1'b1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  function automatic logic [63:0] rot(logic [63:0] p, int k);
    int r = (7 * k) % 64;
    if (r == 0) return p;
    return (p << r) | (p >> (64 - r));
  endfunction

  function automatic logic [15:0] model(logic [1:0] m, logic w, logic sg, int n, logic [63:0] p);
    logic [15:0] acc = '0;
    for (int k = 0; k < n; k++) begin
      logic [63:0] rr = rot(p, k);
      int c = 0, s = 0;
      for (int i = 0; i < 64; i++) begin
        c += int'(rr[i]);
        if ((i % 8) == 7 || (!w && (i % 8) == 3)) s += int'(rr[i]);
      end
      acc = (k == 0) ? 16'(c) : 16'((acc << 1) + 16'(c));
      if (sg && m == 2'd0 && k == 0) acc = 16'(acc - 16'(2 * c));
      if (sg && m != 2'd0 && k == 0) acc = 16'(acc + 16'(2 * c));
      if (sg && m != 2'd0 && k == n - 1) acc = 16'(acc + 16'(2 * s));
    end
    return acc;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at negedge; outputs checked at the negedge after the edge
  task automatic run_group(logic [1:0] m, logic w, logic sg, int n, logic [63:0] p, string tag,
                           output logic [15:0] res);
    for (int k = 0; k < n; k++) begin
      step_valid = 1'b1; first = (k == 0); last = (k == n - 1);
      mode = m; wide = w; sgn = sg; rows = rot(p, k);
      @(negedge clk);
      if (k != n - 1) chk("R3 valid low mid-group", 16'(valid), 16'd0);
    end
    step_valid = 1'b0; first = 1'b0; last = 1'b0;
    chk("R3 valid after last", 16'(valid), 16'd1);
    chk(tag, result, model(m, w, sg, n, p));
    res = result;
  endtask

  initial begin : watchdog
    #(8ns * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] r, r_a, r_b;
    rows = '1;
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 16'd0);
    chk("R1 valid in reset", 16'(valid), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result after release", result, 16'd0);
    chk("R1 valid after release", 16'(valid), 16'd0);

    foreach (TBL[e]) begin
      logic [70:0] v = TBL[e];
      string tag = !v[67] ? "R2 unsigned" : (v[70:69] == 2'd0) ? "R5 serial signed" :
                   v[68] ? "R7 side signed wide" : "R8 side signed narrow";
      run_group(v[70:69], v[68], v[67], int'(v[66:64]), v[63:0], tag, r);
    end

    // hand-derived corner values
    run_group(2'd2, 1'b1, 1'b0, 1, '1, "R2 all ones unsigned", r);
    chk("R2 all ones = 64", r, 16'd64);
    run_group(2'd0, 1'b1, 1'b1, 1, '1, "R5 serial all ones", r);
    chk("R5 -64 mod 2^16", r, 16'd65472);
    run_group(2'd1, 1'b1, 1'b1, 1, '1, "R6 side all ones wide", r);
    chk("R6 R7 64+128+16", r, 16'd208);
    run_group(2'd1, 1'b0, 1'b1, 1, '1, "R8 side all ones narrow", r);
    chk("R8 64+128+32", r, 16'd224);
    run_group(2'd1, 1'b0, 1'b1, 1, 64'h8, "R8 row3 narrow", r);
    chk("R8 row3 in subset", r, 16'd5);
    run_group(2'd1, 1'b1, 1'b1, 1, 64'h8, "R7 row3 wide", r);
    chk("R7 row3 not in subset", r, 16'd3);

    // R9: both input-side modes on one pattern
    run_group(2'd1, 1'b0, 1'b1, 5, 64'h1357_9BDF_2468_ACE0, "R9 mode1", r_a);
    run_group(2'd2, 1'b0, 1'b1, 5, 64'h1357_9BDF_2468_ACE0, "R9 mode2", r_b);
    chk("R9 modes agree", r_b, r_a);

    // R10: idle cycles with toggling rows
    for (int k = 0; k < 4; k++) begin
      rows = ~rows ^ 64'(k * 37);
      @(negedge clk);
      chk("R10 result held", result, r_b);
      chk("R10 valid low", 16'(valid), 16'd0);
    end

    // R4: new group starts clean after a nonzero result
    run_group(2'd0, 1'b1, 1'b0, 1, 64'h0000_0000_0000_00FF, "R4 fresh group", r);
    chk("R4 = 8", r, 16'd8);

    // R11: 11 all-ones steps, 64*(2^11-1) mod 2^16
    for (int k = 0; k < 11; k++) begin
      step_valid = 1'b1; first = (k == 0); last = (k == 10);
      mode = 2'd0; wide = 1'b1; sgn = 1'b0; rows = '1;
      @(negedge clk);
    end
    step_valid = 1'b0; first = 1'b0; last = 1'b0;
    chk("R11 wrap", result, 16'd65472);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule